// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable model of a 16-byte serial EEPROM that sits on a two-wire bus: a clock line driven by the host and a shared data line pulled high by an external resistor. The target brings both lines into its own clock domain. It recognises bus framing from data-line edges that occur while the clock line is high, and it shifts in one bit on each clock-high period. After every byte it receives, it either acknowledges that byte or leaves the line alone.

The first byte of a command carries a device code and a direction bit. In a write, the next byte sets the internal word pointer and every later byte is stored at the pointer. A read returns bytes from the pointer for as long as the host acknowledges them. After the host ends a write that stored data, the target runs a timed programming period and ignores its device code until that period is over. The data output is open-drain: the block only ever asks for the line to be pulled low.

Top module: `eep2w_target`

## Requirements
- R1: After reset the target is not pulling the data line, the word pointer is 0, every stored byte is 0x00 and no programming period is running.
- R2: A falling data edge while the clock is high is a START. It aborts any byte in progress, releases the line and makes the next byte a device byte, without changing the pointer.
- R3: A rising data edge while the clock is high is a STOP. It releases the line and returns the target to idle.
- R4: A device byte whose upper nibble is 1010 is acknowledged: the line is held low for the whole high phase of the ninth clock pulse. Any other device byte gets no acknowledge, and all bytes after it are ignored until the next START.
- R5: In a write (device byte bit 0 = 0), the low four bits of the second byte load the pointer. Each later byte is acknowledged, stored at the pointer, and the pointer then advances modulo 16.
- R6: In a read (device byte bit 0 = 1), the target sends the byte at the pointer MSB first, one bit per clock pulse, and the pointer advances modulo 16 after each byte. With no word byte before it, the read starts at the current pointer.
- R7: When the host acknowledges a sent byte (line low on the ninth pulse), the target sends the next byte. When the host does not, the target leaves the line released until the next START or STOP.
- R8: A STOP that ends a write in which at least one byte was stored starts a programming period of WR_CYCLES clocks. During it, no device byte is acknowledged. Once it ends, device bytes are acknowledged again.
- R9: The target only starts pulling the line after a falling clock edge, so its output never changes into a low while the clock is high.
- R10: A STOP after a write that only set the pointer and stored nothing starts no programming period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it samples both bus lines |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Resolved level of the bus data line |
| sda_pull_o | output | 1 | When high, the data line is pulled low; when low, the line floats |

## Verification
The bench first aims at framing. It aborts a word byte halfway with a fresh START and expects the pointer to be unchanged; a target that did not reset its bit counter would read the wrong byte or lose byte alignment. Pointer wrap is tested on both writes and reads across location 15. A design with a wide or unmasked pointer would write or read outside the 16 bytes. The programming period is probed right after a STOP, where an eager target would wrongly acknowledge. It is probed again after a STOP that followed a pointer-only write, where a target that arms on any write would wrongly refuse. A host that does not acknowledge is followed by an extra clock pulse, and the bench checks that the line stays high; a target that kept sending would pull it low.

// File: rtl/eep2w_pkg.sv
// Package for the two-wire EEPROM target: bus-engine states, received-byte
// roles and the fixed device code. Assumes nothing beyond standard types.
package eep2w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_RX,     // shifting in a byte from the host
        ST_ACK,    // holding the line low for the acknowledge pulse
        ST_TX,     // shifting out a byte to the host
        ST_HACK    // sampling the host's acknowledge
    } bus_state_t;

    typedef enum logic [1:0] {
        RX_DEV,    // device code plus direction bit
        RX_WORD,   // word pointer
        RX_DATA    // data to store
    } rx_role_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/eep2w_line_cond.sv
// Bus line conditioner. Brings both bus lines into the clk domain through a
// flop chain, then reports clock edges and START/STOP framing as
// single-cycle pulses. Assumes SYNC_STAGES >= 2 and a bus much slower than clk.
module eep2w_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_now;
    logic                   sda_now;

    // Synchronizer chains; both reset to the idle-high level of the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
        end
    end

    assign scl_now = scl_sync[SYNC_STAGES-1];
    assign sda_now = sda_sync[SYNC_STAGES-1];

    // One-cycle history, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    // Edge and framing decode from the synchronized levels.
    always_comb begin
        sda_lvl   = sda_now;
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        start_det = scl_now & scl_prev & sda_prev & ~sda_now;
        stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/eep2w_wr_timer.sv
// Programming-period timer. A one-cycle start pulse loads a down-counter,
// and busy stays high for exactly WR_CYCLES clocks after that pulse.
// Assumes WR_CYCLES >= 1.
module eep2w_wr_timer #(
    parameter int WR_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] remain_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= CW'(WR_CYCLES);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = (remain_q != '0);

endmodule

// File: rtl/eep2w_store.sv
// Byte array with its word pointer. A write stores at the pointer and
// advances it. A load replaces the pointer, and an increment advances it.
// The read port always shows the byte at the pointer. Assumes DEPTH is a
// power of two, so the pointer wraps by overflow.
module eep2w_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_val,
    input  logic          ptr_inc,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] ptr_q;

    // Array contents; cleared on reset, written at the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[ptr_q] <= wr_data;
        end
    end

    // Word pointer: a load wins, then a write or increment advances it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= ptr_val;
        end else if (wr_en || ptr_inc) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign rd_data = mem_q[ptr_q];

endmodule

// File: rtl/eep2w_bus_fsm.sv
// Bus engine. Shifts bytes in and out on the conditioned clock edges,
// decides whether to acknowledge, drives the open-drain pull request, and
// issues write, pointer-load and pointer-increment strobes to the store.
// START and STOP override every state. Assumes DW >= 4 and AW <= DW.
module eep2w_bus_fsm
    import eep2w_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          busy,
    input  logic [DW-1:0] rd_data,
    output logic          pull,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          ptr_load,
    output logic [AW-1:0] ptr_val,
    output logic          ptr_inc,
    output logic          wr_start
);

    localparam int BW = $clog2(DW + 1);
    localparam logic [BW-1:0] BIT_FULL = BW'(DW);
    localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

    bus_state_t    state_q;
    rx_role_t      role_q;
    logic [BW-1:0] bitcnt_q;
    logic [DW-1:0] sh_q;
    logic          pull_q;
    logic          pend_q;
    logic          hack_q;
    logic          accept;
    logic          byte_in;
    logic          byte_out;

    // Decide whether the byte just shifted in gets an acknowledge.
    always_comb begin
        if (role_q == RX_DEV) begin
            accept = (sh_q[DW-1 -: 4] == DEV_CODE) && !busy;
        end else begin
            accept = 1'b1;
        end
    end

    // Strobes for the store and the timer, derived from state and events.
    always_comb begin
        byte_in  = (state_q == ST_RX) && scl_fall && (bitcnt_q == BIT_FULL)
                   && !start_det && !stop_det;
        byte_out = (state_q == ST_TX) && scl_fall && (bitcnt_q == BIT_LAST)
                   && !start_det && !stop_det;
        wr_en    = byte_in && (role_q == RX_DATA);
        ptr_load = byte_in && (role_q == RX_WORD);
        ptr_inc  = byte_out;
        wr_data  = sh_q;
        ptr_val  = sh_q[AW-1:0];
        wr_start = stop_det && pend_q;
    end

    // Main sequencer: framing overrides, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            role_q   <= RX_DEV;
            bitcnt_q <= '0;
            sh_q     <= '0;
            pull_q   <= 1'b0;
            pend_q   <= 1'b0;
            hack_q   <= 1'b0;
        end else if (start_det) begin
            state_q  <= ST_RX;
            role_q   <= RX_DEV;
            bitcnt_q <= '0;
            pull_q   <= 1'b0;
        end else if (stop_det) begin
            state_q  <= ST_IDLE;
            pull_q   <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_RX: begin
                    if (scl_rise && bitcnt_q != BIT_FULL) begin
                        sh_q     <= {sh_q[DW-2:0], sda_lvl};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    if (scl_fall && bitcnt_q == BIT_FULL) begin
                        if (accept) begin
                            pull_q  <= 1'b1;
                            state_q <= ST_ACK;
                            if (role_q == RX_DATA) begin
                                pend_q <= 1'b1;
                            end
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        pull_q   <= 1'b0;
                        bitcnt_q <= '0;
                        state_q  <= ST_RX;
                        if (role_q == RX_DEV && sh_q[0]) begin
                            state_q <= ST_TX;
                            sh_q    <= rd_data;
                            pull_q  <= ~rd_data[DW-1];
                        end else if (role_q == RX_DEV) begin
                            role_q <= RX_WORD;
                        end else begin
                            role_q <= RX_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt_q == BIT_LAST) begin
                            pull_q  <= 1'b0;
                            state_q <= ST_HACK;
                        end else begin
                            sh_q     <= {sh_q[DW-2:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 1'b1;
                            pull_q   <= ~sh_q[DW-2];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        hack_q <= ~sda_lvl;
                    end
                    if (scl_fall) begin
                        if (hack_q) begin
                            state_q  <= ST_TX;
                            sh_q     <= rd_data;
                            bitcnt_q <= '0;
                            pull_q   <= ~rd_data[DW-1];
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign pull = pull_q;

endmodule

// File: rtl/eep2w_target.sv
// Two-wire serial EEPROM target top. Connects the line conditioner, the bus
// engine, the byte store and the programming timer. The data output is a
// pull-low request for an open-drain pad; sda_i must be the resolved line.
module eep2w_target #(
    parameter int DEPTH       = 16,
    parameter int DATA_W      = 8,
    parameter int WR_CYCLES   = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);

    localparam int AW = $clog2(DEPTH);

    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_busy;
    logic              wr_start;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic              ptr_load;
    logic [AW-1:0]     ptr_val;
    logic              ptr_inc;
    logic [DATA_W-1:0] rd_data;

    eep2w_line_cond #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    eep2w_bus_fsm #(
        .DW(DATA_W),
        .AW(AW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .busy     (wr_busy),
        .rd_data  (rd_data),
        .pull     (sda_pull_o),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .ptr_inc  (ptr_inc),
        .wr_start (wr_start)
    );

    eep2w_store #(
        .DEPTH(DEPTH),
        .DW   (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ptr_load(ptr_load),
        .ptr_val (ptr_val),
        .ptr_inc (ptr_inc),
        .rd_data (rd_data)
    );

    eep2w_wr_timer #(
        .WR_CYCLES(WR_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(wr_start),
        .busy (wr_busy)
    );

endmodule

// File: rtl/eep2w_target_chk.sv
// Checker for the EEPROM target, attached by bind. It watches framing
// pulses, the timer and the pull output. The length of the programming
// period is measured with a counter rather than a long delay.
module eep2w_target_chk #(
    parameter int WR_CYCLES = 300
) (
    input logic clk,
    input logic rst_n,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic wr_busy,
    input logic wr_start,
    input logic sda_pull_o
);

    int busy_cnt;

    // Counts busy cycles since the last programming start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0;
        end else if (wr_start) begin
            busy_cnt <= 0;
        end else if (wr_busy) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    a_r2_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull_o);

    a_r3_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);

    a_r9_pull_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall));

    a_r8_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !$past(wr_busy));

    a_r8_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> wr_busy);

    a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_busy) |-> (busy_cnt == WR_CYCLES));

endmodule

bind eep2w_target eep2w_target_chk #(
    .WR_CYCLES(WR_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_busy   (wr_busy),
    .wr_start  (wr_start),
    .sda_pull_o(sda_pull_o)
);

// File: tb/tb_eep2w_target.sv
// Bench for the EEPROM target. A host model drives the bus. A driver pushes
// expected read bytes into a scoreboard queue, and a monitor pops and
// compares each byte as the host receives it.
module tb_eep2w_target;

    localparam int WR  = 300;
    localparam int Q   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_h = 1'b1;
    logic sda_pull_o;
    logic line;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rx_val;
    event       rx_ev;

    always #2 clk = ~clk;

    assign line = sda_h & ~sda_pull_o;

    eep2w_target #(.WR_CYCLES(WR)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (line),
        .sda_pull_o(sda_pull_o)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Scoreboard monitor: compares each received byte with the queue head.
    always @(rx_ev) begin
        if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard-empty", rx_val, 0);
        end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(rx_val == e, t, rx_val, e);
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_h = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_h = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_h = b; wq(Q);
        scl = 1'b1; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b, output logic stable);
        logic early;
        sda_h = 1'b1; wq(Q);
        scl = 1'b1; wq(2);
        early = line;
        wq(Q - 2);
        b = line;
        stable = (early == b);
        scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string tag);
        logic b, st;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b, st);
        check((!b) == exp_ack, tag, !b, exp_ack);
        if (exp_ack) check(st, "R9 ack held over high phase", st, 1);
    endtask

    task automatic recv_byte(input logic [7:0] e, input string tag, input bit ack);
        logic b, st;
        logic [7:0] v;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            get_bit(b, st);
            v[i] = b;
        end
        put_bit(!ack);
        rx_val = v;
        -> rx_ev;
        wq(1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic b, st;
        wq(6);
        check(sda_pull_o == 1'b0, "R1 line released in reset", sda_pull_o, 0);
        rst_n = 1'b1;
        wq(4);
        check(line == 1'b1, "R1 line idle high", line, 1);

        // Wrong device code: no ack, the rest of the frame is ignored.
        bus_start();
        send_byte(8'h90, 1'b0, "R4 foreign code nack");
        send_byte(8'hA1, 1'b0, "R4 bytes ignored after nack");
        bus_stop();

        // Read at the reset pointer sees cleared storage.
        bus_start();
        send_byte(8'hA1, 1'b1, "R4 code 1010 ack");
        recv_byte(8'h00, "R1 cleared byte", 1'b0);
        bus_stop();

        // Sequential write from 5.
        bus_start();
        send_byte(8'hA0, 1'b1, "R5 dev write ack");
        send_byte(8'h05, 1'b1, "R5 word ack");
        send_byte(8'h3C, 1'b1, "R5 data ack");
        send_byte(8'hC3, 1'b1, "R5 data ack");
        send_byte(8'h5A, 1'b1, "R5 data ack");
        bus_stop();

        // Immediate poll: the programming period refuses the device byte.
        bus_start();
        send_byte(8'hA0, 1'b0, "R8 busy nack");
        bus_stop();
        wq(WR + 20);

        // Random read of 5 and 6; a host nack releases the line.
        bus_start();
        send_byte(8'hA0, 1'b1, "R8 ack after period");
        send_byte(8'h05, 1'b1, "R5 word ack");
        bus_start();
        send_byte(8'hA1, 1'b1, "R6 dev read ack");
        recv_byte(8'h3C, "R5 stored byte at 5", 1'b1);
        recv_byte(8'hC3, "R7 next byte after host ack", 1'b0);
        get_bit(b, st);
        check(b == 1'b1, "R7 line left high after host nack", b, 1);
        bus_stop();
        check(line == 1'b1 && sda_pull_o == 1'b0, "R3 released after stop", line, 1);

        // Current-address read continues at 7.
        bus_start();
        send_byte(8'hA1, 1'b1, "R6 dev read ack");
        recv_byte(8'h5A, "R6 current address byte", 1'b0);
        bus_stop();

        // Write across the top of the array.
        bus_start();
        send_byte(8'hA0, 1'b1, "R5 dev write ack");
        send_byte(8'h0E, 1'b1, "R5 word ack");
        send_byte(8'h11, 1'b1, "R5 data ack");
        send_byte(8'h22, 1'b1, "R5 data ack");
        send_byte(8'h33, 1'b1, "R5 wrap data ack");
        bus_stop();
        wq(WR + 20);

        // Read across the top of the array.
        bus_start();
        send_byte(8'hA0, 1'b1, "R6 dev write ack");
        send_byte(8'h0F, 1'b1, "R6 word ack");
        bus_start();
        send_byte(8'hA1, 1'b1, "R6 dev read ack");
        recv_byte(8'h22, "R6 byte at 15", 1'b1);
        recv_byte(8'h33, "R6 wrapped byte at 0", 1'b0);
        bus_stop();

        // Pointer-only write: no programming period follows.
        bus_start();
        send_byte(8'hA0, 1'b1, "R10 dev write ack");
        send_byte(8'h06, 1'b1, "R10 word ack");
        bus_stop();
        bus_start();
        send_byte(8'hA1, 1'b1, "R10 no busy after pointer-only write");
        recv_byte(8'hC3, "R10 byte at loaded pointer", 1'b0);
        bus_stop();

        // START in the middle of a word byte; pointer stays at 7.
        bus_start();
        send_byte(8'hA0, 1'b1, "R2 dev write ack");
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(8'hA1, 1'b1, "R2 dev byte after abort");
        recv_byte(8'h5A, "R2 pointer unchanged by abort", 1'b0);
        bus_stop();

        wq(10);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule